// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small 8-bit processor core. It decides whether an interrupt is taken at the current instruction boundary and, if so, which vector the core jumps to. Each source raises a one-cycle set pulse. The block latches that pulse as a pending flag and holds it until the source is serviced. A source is eligible only when three things are true at once: its pending flag is set, its per-source enable is high, and the block's global enable is set. Among the eligible sources, the one with the lowest vector address wins.

The core reports its progress through a few strobes:
- an instruction-completed strobe;
- set-global-enable and clear-global-enable strobes;
- a plain return strobe;
- a return-from-interrupt strobe.

On acceptance the block does several things in one registered cycle. It issues a one-cycle take request together with the vector word address. It pulses requests to push the next-instruction address and to clear the global enable. It acknowledges the serviced source and clears that source's pending flag. The vector table has two 16-bit words per entry, and word 0 is the reset entry. Source `i` therefore vectors to word address `2*(i+1)`.

Top module: `vic_irq_ctrl`

## Requirements
- R1: An interrupt is accepted only in a cycle where `insn_done_i` is high, the global enable is set, and some source has both its pending flag and `irq_en_i` bit high. `take_o` is high for exactly the one cycle after the accepting cycle. A cycle without `insn_done_i` never produces a take.
- R2: With `take_o`, `vec_o` carries the word address `2*(i+1)` of the accepted source `i` (bit `i` of the source vectors). `vec_o` holds its value between acceptances.
- R3: When several sources are eligible at once, the lowest index wins. Source 0 at word 0x0002 beats source 6 at word 0x000E.
- R4: In the take cycle, `push_pc_o` and `gie_clr_o` are high, and `gie_o` reads 0. Entry clears the global enable even if `sei_i` is high in the accepting cycle.
- R5: `reti_i` sets the global enable at the next edge. `ret_i` leaves it unchanged.
- R6: `reti_i` is given in the same cycle as the `insn_done_i` of the return instruction. No interrupt is accepted in that cycle, even when the global enable is already set. The next instruction boundary may accept.
- R7: A set pulse that arrives while the global enable or the source enable is low is held. It is serviced by priority once both are set.
- R8: `ack_o` is the one-hot code of the serviced source, high only in the take cycle. That source's pending flag clears at the same edge, so the source is not taken again without a new set pulse.
- R9: A set pulse on a source in the cycle it is accepted leaves the flag pending, so the source is taken again.
- R10: `sei_i` sets and `cli_i` clears the global enable at the next edge. `cli_i` wins over `sei_i` and `reti_i`.
- R11: With `rst_ni` low, all pending flags, the global enable and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_set_i | input | NUM_SRC | Per-source set pulses |
| irq_en_i | input | NUM_SRC | Per-source enables |
| insn_done_i | input | 1 | Core completed an instruction this cycle |
| sei_i | input | 1 | Set global enable |
| cli_i | input | 1 | Clear global enable |
| ret_i | input | 1 | Plain return completed |
| reti_i | input | 1 | Return-from-interrupt completed |
| take_o | output | 1 | One-cycle interrupt take request |
| vec_o | output | VEC_AW | Vector word address |
| push_pc_o | output | 1 | Push next-instruction address |
| gie_clr_o | output | 1 | Global enable cleared on entry |
| ack_o | output | NUM_SRC | One-hot serviced-source acknowledge |
| gie_o | output | 1 | Current global enable |

## Verification
The bench first aims at the return boundary. It enables interrupts inside a handler and then returns while a second source is pending. A design that let the return boundary accept would issue a take right after `reti_i`, and the interrupted program would get no instruction in between. The bench also fires two sources together, to catch a design that inverts the priority and vectors to 0x000E. It re-sets a source in the very cycle that source is accepted, to catch a design that lets the hardware clear win and loses the event. It gives `ret_i` and `reti_i` separately, to catch a design that confuses them, and it holds flags through disabled periods and cycles with no instruction boundary.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned WORDS_PER_ENTRY = 2;

  // word address of the entry after the reset entry
  function automatic int unsigned entry_word(input int unsigned src);
    return (src + 1) * WORDS_PER_ENTRY;
  endfunction
endpackage

// File: rtl/vic_pend_bank.sv
module vic_pend_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_q[g] <= 1'b0;
      else if (set_i[g])   pend_q[g] <= 1'b1;  // new event beats service clear
      else if (clr_i[g])   pend_q[g] <= 1'b0;
    end

    // R7
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_q[g]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IW-1:0]      idx_o,
  output logic [NUM_SRC-1:0] onehot_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  always_comb onehot_o = any_o ? (NUM_SRC'(1) << idx_o) : '0;

  always_comb begin
    // R3
    lowest_wins_chk: assert (((onehot_o - NUM_SRC'(1)) & req_i) == '0 || !any_o);
  end
endmodule

// File: rtl/vic_gie_ctrl.sv
module vic_gie_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic entry_i,
  input  logic sei_i,
  input  logic cli_i,
  input  logic ret_i,
  input  logic reti_i,
  output logic gie_o
);
  logic gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gie_q <= 1'b0;
    else if (entry_i)         gie_q <= 1'b0;
    else if (cli_i)           gie_q <= 1'b0;
    else if (sei_i || reti_i) gie_q <= 1'b1;
  end

  assign gie_o = gie_q;

  // R4
  entry_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |=> !gie_q);
  // R5
  ret_keeps_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !reti_i && !sei_i && !cli_i && !entry_i) |=> gie_q == $past(gie_q));
  // R5
  reti_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !cli_i && !entry_i) |=> gie_q);
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_AW  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_set_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               insn_done_i,
  input  logic               sei_i,
  input  logic               cli_i,
  input  logic               ret_i,
  input  logic               reti_i,
  output logic               take_o,
  output logic [VEC_AW-1:0]  vec_o,
  output logic               push_pc_o,
  output logic               gie_clr_o,
  output logic [NUM_SRC-1:0] ack_o,
  output logic               gie_o
);
  import vic_pkg::*;

  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend, req, win_oh, clr;
  logic [IW-1:0]      win_idx;
  logic               win_any, gie, accept;
  logic               take_q;
  logic [VEC_AW-1:0]  vec_q, vec_d;
  logic [NUM_SRC-1:0] ack_q;

  assign req    = pend & irq_en_i;
  // return boundary never accepts: one more main-program instruction first
  assign accept = insn_done_i && gie && !reti_i && win_any;
  assign clr    = accept ? win_oh : '0;
  assign vec_d  = VEC_AW'(entry_word(32'(win_idx)));

  vic_pend_bank #(.NUM_SRC(NUM_SRC)) i_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (irq_set_i),
    .clr_i (clr),
    .pend_o(pend)
  );

  vic_prio_pick #(.NUM_SRC(NUM_SRC)) i_pick (
    .req_i   (req),
    .any_o   (win_any),
    .idx_o   (win_idx),
    .onehot_o(win_oh)
  );

  vic_gie_ctrl i_gie (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .entry_i(accept),
    .sei_i  (sei_i),
    .cli_i  (cli_i),
    .ret_i  (ret_i),
    .reti_i (reti_i),
    .gie_o  (gie)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      ack_q  <= '0;
      vec_q  <= '0;
    end else begin
      take_q <= accept;
      ack_q  <= clr;
      if (accept) vec_q <= vec_d;
    end
  end

  assign take_o    = take_q;
  assign vec_o     = vec_q;
  assign push_pc_o = take_q;
  assign gie_clr_o = take_q;
  assign ack_o     = ack_q;
  assign gie_o     = gie;

  // R1
  take_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(insn_done_i));
  // R1
  take_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  // R6
  reti_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !take_o);
  // R8
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $onehot(ack_o));
  // R8
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> ack_o == '0);
  // R4
  take_gie_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !gie_o);
endmodule

// File: tb/test_vic_irq_ctrl.sv
`timescale 1ns/1ps
module test_vic_irq_ctrl;
  localparam int N  = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] s_set = '0, s_en = '0;
  logic s_done = 1'b0, s_sei = 1'b0, s_cli = 1'b0, s_ret = 1'b0, s_reti = 1'b0;

  logic          take, push, gclr, gie;
  logic [AW-1:0] vec;
  logic [N-1:0]  ack;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vic_irq_ctrl #(.NUM_SRC(N), .VEC_AW(AW)) i_vic_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_set_i(s_set), .irq_en_i(s_en),
    .insn_done_i(s_done), .sei_i(s_sei), .cli_i(s_cli), .ret_i(s_ret),
    .reti_i(s_reti), .take_o(take), .vec_o(vec), .push_pc_o(push),
    .gie_clr_o(gclr), .ack_o(ack), .gie_o(gie)
  );

  // behavioural reference
  bit         m_take, m_gie;
  int         m_vec;
  bit [N-1:0] m_ack, m_pend;
  int         m_sel;
  bit         m_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_take = 0; m_gie = 0; m_vec = 0; m_ack = '0; m_pend = '0;
    end else begin
      m_sel = -1;
      for (int i = 0; i < N; i++)
        if (m_sel < 0 && m_pend[i] && s_en[i]) m_sel = i;
      m_acc  = s_done && m_gie && !s_reti && (m_sel >= 0);
      m_take = m_acc;
      m_ack  = '0;
      if (m_acc) begin
        m_ack[m_sel] = 1'b1;
        m_vec = 2 * (m_sel + 1);
      end
      for (int i = 0; i < N; i++) begin
        if (s_set[i]) m_pend[i] = 1'b1;
        else if (m_acc && i == m_sel) m_pend[i] = 1'b0;
      end
      if (m_acc) m_gie = 0;
      else if (s_cli) m_gie = 0;
      else if (s_sei || s_reti) m_gie = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(take == m_take, "R1 take_o", int'(take), int'(m_take));
    chk(int'(vec) == m_vec, "R2 vec_o", int'(vec), m_vec);
    chk(push == m_take && gclr == m_take, "R4 push/gie_clr", int'({push, gclr}), int'({m_take, m_take}));
    chk(ack == m_ack, "R8 ack_o", int'(ack), int'(m_ack));
    chk(gie == m_gie, "R5 gie_o", int'(gie), int'(m_gie));
  endtask

  task automatic step(input logic [N-1:0] set, input bit done, input bit sei = 0,
                      input bit cli = 0, input bit ret = 0, input bit reti = 0);
    s_set = set; s_done = done; s_sei = sei; s_cli = cli; s_ret = ret; s_reti = reti;
    @(posedge clk);
    @(negedge clk);
    s_set = '0; s_done = 0; s_sei = 0; s_cli = 0; s_ret = 0; s_reti = 0;
    cmp_model();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    s_en = '1;
    s_set = 8'hFF; s_done = 1; s_sei = 1;
    repeat (3) @(negedge clk);
    // R11
    chk(!take && vec == 0 && ack == 0 && !gie && !push && !gclr, "R11 reset outputs",
        int'({take, gie, ack}), 0);
    s_set = '0; s_done = 0; s_sei = 0;
    rst_n = 1'b1;
    step('0, 1);
    chk(!take, "R11 no leftover pending", int'(take), 0);

    // R7 held while global enable low; R3 priority 0 over 6
    step(8'h41, 1);
    step('0, 1);
    chk(!take, "R7 held while gie low", int'(take), 0);
    step('0, 1, 1);
    // R10
    chk(gie && !take, "R10 sei sets gie", int'({gie, take}), 2);
    step('0, 1);
    chk(take && vec == 2, "R3 lowest index wins", int'(vec), 2);
    chk(ack == 8'h01 && push && gclr && !gie, "R4 entry effects", int'(ack), 1);

    // R6 nested sei then return while source 6 pends
    step('0, 0, 1);
    step('0, 1, 0, 0, 0, 1);
    chk(!take && gie, "R6 no take at return boundary", int'(take), 0);
    step('0, 1);
    chk(take && vec == 14, "R6 take one boundary later", int'(vec), 14);

    // R5 plain return keeps gie low
    step('0, 1, 0, 0, 1, 0);
    chk(!gie, "R5 ret leaves gie", int'(gie), 0);
    step('0, 1, 0, 0, 0, 1);
    chk(gie, "R5 reti sets gie", int'(gie), 1);

    // R8 serviced flag cleared: no repeat take
    step('0, 1);
    chk(!take, "R8 no stale pending", int'(take), 0);

    // R7/R1 source enable gating
    s_en = 8'hF7;
    step(8'h08, 1);
    step('0, 1);
    chk(!take && gie, "R7 held while source disabled", int'(take), 0);
    s_en = '1;
    step('0, 0);
    step('0, 0);
    chk(!take, "R1 no take without boundary", int'(take), 0);
    step('0, 1);
    chk(take && vec == 8, "R1 take on boundary", int'(vec), 8);

    // R9 set coinciding with acceptance
    step('0, 0, 1);
    step(8'h04, 1);
    step(8'h04, 1);
    chk(take && vec == 6, "R9 first take", int'(vec), 6);
    step('0, 0, 1);
    step('0, 1);
    chk(take && vec == 6, "R9 retaken after re-set", int'(vec), 6);

    // R10 cli wins over sei; R4 entry beats sei
    step('0, 0, 1, 1);
    chk(!gie, "R10 cli beats sei", int'(gie), 0);
    step('0, 0, 1);
    step(8'h10, 0);
    step('0, 1, 1);
    chk(take && !gie, "R4 entry beats sei", int'(gie), 0);
    step('0, 1);
    chk(!take, "R2 vec held", int'(vec), 10);
    chk(vec == 10, "R2 vec held value", int'(vec), 10);

    // random traffic against the reference
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] rs;
      bit d, se, cl, rt, ri;
      for (int b = 0; b < N; b++) rs[b] = ($urandom % 10) == 0;
      if (($urandom % 32) == 0) s_en = N'($urandom);
      d  = ($urandom % 2) == 0;
      se = ($urandom % 8) == 0;
      cl = ($urandom % 20) == 0;
      ri = d && (($urandom % 12) == 0);
      rt = d && !ri && (($urandom % 12) == 0);
      step(rs, d, se, cl, rt, ri);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule